// File: doc/BRIEF.md
# Freezable Software Watchdog Timer

The block is a software watchdog built around a 16-bit down-counter. Each count step comes either from every system clock cycle or from an 11-bit prescaler that divides by 2048. Software keeps the watchdog from expiring by writing a two-word service sequence, which reloads the counter from a programmed timeout value. If the counter runs out, the block raises a one-cycle request. A configuration bit decides whether that request is a reset request or a non-maskable interrupt. After each expiry the counter reloads by itself.

Two conditions stop the count, and in both cases the count is held and not cleared. A debug freeze input stops the count only when the freeze-stop bit is set. A low-power-mode input always stops it. While the count is stopped, the prescaler also holds its value, so no part of a prescale period is lost.

The service logic is a two-state machine. `SVC_IDLE` waits for the arming word 16'h556C. On that word the transition *arm* moves it to `SVC_ARMED`. In `SVC_ARMED`, the word 16'hAA39 takes the transition *fire*: it issues the reload and goes back to `SVC_IDLE`. A repeated arming word takes *rearm* and stays in `SVC_ARMED`. Any other word takes *abort* and goes back to `SVC_IDLE` without a reload. In `SVC_IDLE`, any word other than the arming word takes *ignore* and the state does not change.

Top module: `sw_watchdog`

## Requirements
- R1: After reset the block has these settings: enable = 1, prescaler selected, reset chosen as the timeout action, freeze-stop = 0, timeout value 16'hFFFF. After reset, `count` = 16'hFFFF and both timeout outputs are low.
- R2: When `cfg_div_sel`=1, the counter steps down once per 2048 cycles in which the block is enabled and not stopped. After reset, the first step lands on the 2048th rising edge.
- R3: When `cfg_div_sel`=0, the counter steps down on every rising edge in which the block is enabled and not stopped.
- R4: A step taken while `count` is 1 or 0 is an expiry. On an expiry, `count` reloads with the timeout value on the same edge, and exactly one output is high for one cycle: `to_reset` if `cfg_nmi_sel`=0, `to_nmi` if `cfg_nmi_sel`=1.
- R5: A service write of 16'h556C followed by a service write of 16'hAA39 reloads `count` with the timeout value on the edge of the second write. The reload has priority over a step on that same edge.
- R6: Any other word written between the two keys restarts the sequence. A lone 16'hAA39 that does not follow 16'h556C has no effect on `count`.
- R7: While `dbg_freeze`=1 and freeze-stop=1, `count` holds its value, and counting resumes when the freeze is released.
- R8: While freeze-stop=0, `dbg_freeze` has no effect on counting.
- R9: While `lowpwr`=1, `count` holds its value, whatever the freeze-stop setting.
- R10: A valid service sequence is accepted while the count is stopped and reloads `count`. Counting stays halted until the count is no longer stopped.
- R11: While enable=0, `count` holds its value and no timeout output is raised.
- R12: A `cfg_we` strobe latches all configuration fields on its rising edge. The new timeout value only reaches `count` at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable value to latch |
| cfg_div_sel | input | 1 | 1 = step through the divide-by-2048 prescaler |
| cfg_nmi_sel | input | 1 | 1 = expiry raises NMI, 0 = expiry raises reset |
| cfg_freeze_stop | input | 1 | 1 = debug freeze stops counting |
| cfg_timeout | input | 16 | Reload value to latch |
| svc_we | input | 1 | Service word write strobe |
| svc_data | input | 16 | Service word |
| dbg_freeze | input | 1 | Debug freeze input |
| lowpwr | input | 1 | Processor in a low-power mode |
| count | output | 16 | Current counter value |
| to_reset | output | 1 | One-cycle reset request on expiry |
| to_nmi | output | 1 | One-cycle NMI request on expiry |

## Verification
The bench drives inputs on falling edges. A write, a freeze change or a configuration change therefore acts on the next rising edge, and `count` and both timeout pulses are registered on that same edge. For each stimulus, the driver pushes the expected `count` and pulse values for the first falling edge after the edge that acts. The monitor compares them shortly after that falling edge. In prescaled mode the first step falls on the 2048th rising edge after reset, so the driver checks the value one edge before that step and again on the step itself.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic {
        SVC_IDLE  = 1'b0,
        SVC_ARMED = 1'b1
    } svc_state_t;

    localparam logic [15:0] SVC_KEY_ARM  = 16'h556C;
    localparam logic [15:0] SVC_KEY_FIRE = 16'hAA39;
endpackage

// File: rtl/swd_prescaler.sv
module swd_prescaler #(
    parameter int DIV_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic wrap
);
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   div_q <= '0;
        else if (run) div_q <= div_q + 1'b1;
    end

    assign wrap = run && (&div_q);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> div_q == $past(div_q));
endmodule

// File: rtl/swd_service_fsm.sv
module swd_service_fsm
    import swd_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         svc_we,
    input  logic [W-1:0] svc_data,
    output logic         load
);
    svc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        if (svc_we) begin
            unique case (state_q)
                SVC_IDLE: begin
                    if (svc_data == W'(SVC_KEY_ARM)) state_d = SVC_ARMED;
                end
                SVC_ARMED: begin
                    if (svc_data == W'(SVC_KEY_FIRE)) begin
                        load    = 1'b1;
                        state_d = SVC_IDLE;
                    end else if (svc_data == W'(SVC_KEY_ARM)) begin
                        state_d = SVC_ARMED;
                    end else begin
                        state_d = SVC_IDLE;
                    end
                end
                default: state_d = SVC_IDLE;
            endcase
        end
    end

    // R6
    fire_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q == SVC_IDLE);
endmodule

// File: rtl/swd_counter.sv
module swd_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic         nmi_sel,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count,
    output logic         to_reset,
    output logic         to_nmi
);
    logic expire;

    assign expire = step && !load && (count <= W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '1;
            to_reset <= 1'b0;
            to_nmi   <= 1'b0;
        end else begin
            to_reset <= expire && !nmi_sel;
            to_nmi   <= expire && nmi_sel;
            if (load || expire) count <= reload_val;
            else if (step)      count <= count - 1'b1;
        end
    end

    // R4
    single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({to_reset, to_nmi}));
    // R4
    expiry_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_reset || to_nmi) |-> count == $past(reload_val));
endmodule

// File: rtl/sw_watchdog.sv
module sw_watchdog #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_enable,
    input  logic             cfg_div_sel,
    input  logic             cfg_nmi_sel,
    input  logic             cfg_freeze_stop,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic             svc_we,
    input  logic [CNT_W-1:0] svc_data,
    input  logic             dbg_freeze,
    input  logic             lowpwr,
    output logic [CNT_W-1:0] count,
    output logic             to_reset,
    output logic             to_nmi
);
    logic             en_q, div_q, nmi_q, fstop_q;
    logic [CNT_W-1:0] timeout_q;
    logic             halted, run, pre_wrap, step, svc_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b1;
            div_q     <= 1'b1;
            nmi_q     <= 1'b0;
            fstop_q   <= 1'b0;
            timeout_q <= '1;
        end else if (cfg_we) begin
            en_q      <= cfg_enable;
            div_q     <= cfg_div_sel;
            nmi_q     <= cfg_nmi_sel;
            fstop_q   <= cfg_freeze_stop;
            timeout_q <= cfg_timeout;
        end
    end

    assign halted = lowpwr || (dbg_freeze && fstop_q);
    assign run    = en_q && !halted;
    assign step   = run && (div_q ? pre_wrap : 1'b1);

    swd_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .wrap(pre_wrap)
    );

    swd_service_fsm #(.W(CNT_W)) u_svc (
        .clk(clk), .rst_n(rst_n), .svc_we(svc_we), .svc_data(svc_data),
        .load(svc_load)
    );

    swd_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .load(svc_load),
        .nmi_sel(nmi_q), .reload_val(timeout_q), .count(count),
        .to_reset(to_reset), .to_nmi(to_nmi)
    );

    // R7
    halted_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !svc_load) |=> count == $past(count));
    // R11
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !(to_reset || to_nmi));
    // R5
    service_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_load |=> count == $past(timeout_q));
endmodule

// File: tb/tb_sw_watchdog.sv
module tb_sw_watchdog;
    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic        rst;
        logic        nmi;
    } exp_t;

    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0, cfg_enable = 0, cfg_div_sel = 0, cfg_nmi_sel = 0, cfg_freeze_stop = 0;
    logic [15:0] cfg_timeout = 0, svc_data = 0;
    logic        svc_we = 0, dbg_freeze = 0, lowpwr = 0;
    logic [15:0] count;
    logic        to_reset, to_nmi;

    exp_t q[$];
    int   n_checks = 0, n_fail = 0;
    bit   finished = 0;

    always #5 clk = ~clk;

    sw_watchdog dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .cfg_div_sel(cfg_div_sel), .cfg_nmi_sel(cfg_nmi_sel),
        .cfg_freeze_stop(cfg_freeze_stop), .cfg_timeout(cfg_timeout),
        .svc_we(svc_we), .svc_data(svc_data), .dbg_freeze(dbg_freeze),
        .lowpwr(lowpwr), .count(count), .to_reset(to_reset), .to_nmi(to_nmi)
    );

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag, input logic [15:0] c,
                              input logic r, input logic m);
        exp_t e;
        e.tag = tag; e.cnt = c; e.rst = r; e.nmi = m;
        q.push_back(e);
    endtask

    task automatic write_cfg(input logic en, input logic dv, input logic nm,
                             input logic fs, input logic [15:0] to);
        cfg_we = 1; cfg_enable = en; cfg_div_sel = dv; cfg_nmi_sel = nm;
        cfg_freeze_stop = fs; cfg_timeout = to;
        cycles(1);
        cfg_we = 0;
    endtask

    task automatic write_svc(input logic [15:0] w);
        svc_we = 1; svc_data = w;
        cycles(1);
        svc_we = 0;
    endtask

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (count !== e.cnt || to_reset !== e.rst || to_nmi !== e.nmi) begin
                    n_fail++;
                    $display("FAIL %s: count=%h rst=%b nmi=%b expected count=%h rst=%b nmi=%b",
                             e.tag, count, to_reset, to_nmi, e.cnt, e.rst, e.nmi);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(2);
        rst_n = 1;
        expect_now("R1 reset state", 16'hFFFF, 0, 0);
        cycles(2047);
        expect_now("R2 no step before 2048", 16'hFFFF, 0, 0);
        cycles(1);
        expect_now("R2 step at 2048", 16'hFFFE, 0, 0);

        write_cfg(1, 0, 0, 1, 16'd5);
        expect_now("R12 cfg does not reload", 16'hFFFE, 0, 0);
        write_svc(16'h556C);
        write_svc(16'hAA39);
        expect_now("R5 service reload", 16'd5, 0, 0);
        cycles(1);
        expect_now("R3 undivided step", 16'd4, 0, 0);
        cycles(3);
        expect_now("R3 count reaches 1", 16'd1, 0, 0);
        cycles(1);
        expect_now("R4 expiry reset pulse", 16'd5, 1, 0);
        cycles(1);
        expect_now("R4 pulse single cycle", 16'd4, 0, 0);

        dbg_freeze = 1;
        cycles(3);
        expect_now("R7 freeze holds", 16'd4, 0, 0);
        dbg_freeze = 0;
        cycles(1);
        expect_now("R7 resume after freeze", 16'd3, 0, 0);

        write_cfg(1, 0, 0, 0, 16'd5);
        dbg_freeze = 1;
        cycles(1);
        expect_now("R8 freeze ignored", 16'd1, 0, 0);
        cycles(1);
        expect_now("R8 expiry under ignored freeze", 16'd5, 1, 0);
        dbg_freeze = 0;

        lowpwr = 1;
        cycles(4);
        expect_now("R9 low power holds", 16'd5, 0, 0);
        lowpwr = 0;
        cycles(2);
        expect_now("R9 resumes", 16'd3, 0, 0);
        lowpwr = 1;
        cycles(2);
        expect_now("R9 hold again", 16'd3, 0, 0);
        write_svc(16'h556C);
        write_svc(16'hAA39);
        expect_now("R10 service while halted", 16'd5, 0, 0);
        cycles(2);
        expect_now("R10 still halted", 16'd5, 0, 0);
        lowpwr = 0;
        cycles(1);
        expect_now("R10 resumes after release", 16'd4, 0, 0);

        write_svc(16'h556C);
        write_svc(16'h1234);
        write_svc(16'hAA39);
        expect_now("R6 broken sequence no reload", 16'd1, 0, 0);
        cycles(1);
        expect_now("R6 expiry after broken seq", 16'd5, 1, 0);

        write_cfg(1, 0, 1, 0, 16'd5);
        cycles(2);
        expect_now("R4 nmi countdown", 16'd2, 0, 0);
        cycles(1);
        cycles(1);
        expect_now("R4 expiry nmi pulse", 16'd5, 0, 1);

        write_cfg(0, 0, 0, 0, 16'd5);
        expect_now("R11 cfg edge still counts", 16'd4, 0, 0);
        cycles(10);
        expect_now("R11 disabled holds", 16'd4, 0, 0);

        cycles(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule